// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the software-facing register set of a four-channel DMA controller with an 8-bit data port. A host reaches it over a simple synchronous I/O bus: a 4-bit offset, a chip select and read and write strobes. Each channel keeps a 16-bit address and a 16-bit word count. Each of these has a base copy and a current copy. Each channel also has a mode byte and a mask bit. A global disable bit, a status register and a software request register are shared by all four channels.

Both 16-bit registers of a channel go through one byte-wide port. A single shared byte pointer decides which half each access touches. A per-channel step pulse stands in for one completed transfer. It moves the current address, counts the word count down, and handles terminal count: the channel either reloads itself or masks itself. The block drives one enable line per channel. An enable is high only when that channel is unmasked and the controller is not disabled.

Top module: `dma4_regfile`

## Requirements
- R1: Offset 2n is the address port of channel n and offset 2n+1 is its count port (n = 0..3). A write to either port loads the addressed byte into both the base copy and the current copy. A read returns the addressed byte of the current copy.
- R2: Every access to offsets 0..7 toggles the shared byte pointer. Pointer low selects bits 7:0 and pointer high selects bits 15:8. A write of any value to offset 12 forces the pointer low.
- R3: A write to offset 10 picks the channel with data bits 1:0. Data bit 2 = 1 masks that channel and data bit 2 = 0 unmasks it.
- R4: A write to offset 15 loads all four masks at once, with data bit n giving channel n's mask. A write to offset 14 clears all four masks.
- R5: A write to offset 13 forces the pointer low and clears the terminal-count and software-request flags. It also masks all four channels. Reset leaves this same state, with every other register at zero.
- R6: A write to offset 11 picks the channel with data bits 1:0 and stores data bits 7:2 as that channel's mode. Mode bit 2 (data bit 4) enables auto-reload and mode bit 3 (data bit 5) selects decrement. Channel n's stored mode appears on chan_mode[6n+5:6n].
- R7: A write to offset 8 with data bit 2 = 1 drives every chan_en low. A later write with bit 2 = 0 restores chan_en to the inverse of the masks.
- R8: A step pulse on an enabled channel adds 1 to its current address, or subtracts 1 in decrement mode. It also subtracts 1 from the current count. A step on a disabled channel changes nothing.
- R9: A step that finds the current count at 0 sets the channel's terminal-count flag. Without auto-reload, the count becomes 0xFFFF and the channel masks itself.
- R10: With auto-reload set, such a terminal step copies the base address and base count into the current copies, and the channel stays unmasked.
- R11: A read of offset 8 returns the terminal-count flags in bits 3:0. Bits 7:4 hold the OR of the dreq input and the software request flags. A write to offset 9 sets (data bit 2 = 1) or clears that flag for the channel in data bits 1:0. The status read clears the terminal-count flags, but a flag set by a step in the same cycle survives.
- R12: A step on channel n in the same cycle as a bus write to channel n's address or count port is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access (takes precedence over rd) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while cs and rd are high |
| dreq | input | 4 | Hardware request lines, reflected in status bits 7:4 |
| step | input | 4 | Per-channel transfer-step pulses |
| chan_en | output | 4 | Per-channel enable |
| chan_mode | output | 24 | Stored mode fields, six bits per channel |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a status read and a terminal-count step land together. The bench holds the status read on the bus in the exact cycle it pulses the final step of a channel. It expects the read to return the old flags and the flag to still be set on the next read. In the second pair, a byte write to a channel's count port coincides with a step on that channel. The bench expects the written low byte combined with the unchanged high byte, which shows that the step was dropped and not merged.

// File: rtl/dma4_regfile.sv
module dma4_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [3:0]  dreq,
  input  logic [3:0]  step,
  output logic [3:0]  chan_en,
  output logic [23:0] chan_mode
);
  logic [15:0] base_a [4];
  logic [15:0] cur_a  [4];
  logic [15:0] base_c [4];
  logic [15:0] cur_c  [4];
  logic [5:0]  mode   [4];
  logic [3:0]  mask, tc, sreq, step_ok, hit;
  logic        dis, ptr;
  logic [15:0] sel;

  wire we      = cs & wr;
  wire re      = cs & rd & ~wr;
  wire st_rd   = re & (addr == 4'd8);

  assign chan_en = ~mask & {4{~dis}};

  always_comb begin
    for (int n = 0; n < 4; n++) begin
      step_ok[n] = step[n] & chan_en[n] & ~(we & ~addr[3] & (addr[2:1] == 2'(n)));
      hit[n]     = step_ok[n] & (cur_c[n] == 16'h0000);
      chan_mode[n*6 +: 6] = mode[n];
    end
  end

  always_comb begin
    sel   = addr[0] ? cur_c[addr[2:1]] : cur_a[addr[2:1]];
    rdata = 8'h00;
    if (re) begin
      if (!addr[3])        rdata = ptr ? sel[15:8] : sel[7:0];
      else if (addr == 4'd8) rdata = {dreq | sreq, tc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) begin
        base_a[n] <= '0; cur_a[n] <= '0;
        base_c[n] <= '0; cur_c[n] <= '0;
        mode[n]   <= '0;
      end
      mask <= 4'hF; tc <= '0; sreq <= '0; dis <= 1'b0; ptr <= 1'b0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        if (step_ok[n]) begin
          cur_a[n] <= mode[n][3] ? cur_a[n] - 16'd1 : cur_a[n] + 16'd1;
          cur_c[n] <= cur_c[n] - 16'd1;
          if (hit[n]) begin
            if (mode[n][2]) begin
              cur_a[n] <= base_a[n];
              cur_c[n] <= base_c[n];
            end else begin
              mask[n] <= 1'b1;
            end
          end
        end
      end
      tc <= (st_rd ? 4'h0 : tc) | hit;
      if ((we || re) && !addr[3]) ptr <= ~ptr;
      if (we) begin
        if (!addr[3]) begin
          if (!addr[0]) begin
            if (ptr) begin
              base_a[addr[2:1]][15:8] <= wdata; cur_a[addr[2:1]][15:8] <= wdata;
            end else begin
              base_a[addr[2:1]][7:0]  <= wdata; cur_a[addr[2:1]][7:0]  <= wdata;
            end
          end else begin
            if (ptr) begin
              base_c[addr[2:1]][15:8] <= wdata; cur_c[addr[2:1]][15:8] <= wdata;
            end else begin
              base_c[addr[2:1]][7:0]  <= wdata; cur_c[addr[2:1]][7:0]  <= wdata;
            end
          end
        end else begin
          case (addr[2:0])
            3'd0: dis <= wdata[2];
            3'd1: sreq[wdata[1:0]] <= wdata[2];
            3'd2: mask[wdata[1:0]] <= wdata[2];
            3'd3: mode[wdata[1:0]] <= wdata[7:2];
            3'd4: ptr <= 1'b0;
            3'd5: begin ptr <= 1'b0; mask <= 4'hF; sreq <= '0; tc <= '0; end
            3'd6: mask <= 4'h0;
            default: mask <= wdata[3:0];
          endcase
        end
      end
    end
  end

  a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd12) |=> !ptr);

  a_r5_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd13) |=> (chan_en == 4'h0 && tc == 4'h0 && !ptr));

  a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd8 && wdata[2]) |=> (chan_en == 4'h0));

  for (genvar g = 0; g < 4; g++) begin : g_chk
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ok[g] && !hit[g]) |=> (cur_c[g] == $past(cur_c[g]) - 16'd1));

    a_r9_tc_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !mode[g][2] && !(we && addr[3])) |=> (tc[g] && !chan_en[g]));

    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && mode[g][2]) |=> (cur_a[g] == $past(base_a[g]) && cur_c[g] == $past(base_c[g])));

    a_r11_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tc[g] && !st_rd && !(we && addr == 4'd13)) |=> tc[g]);
  end
endmodule

// File: tb/dma4_regfile_bench.sv
module dma4_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] dreq = '0, step = '0;
  logic [3:0] chan_en;
  logic [23:0] chan_mode;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  dma4_regfile u_dma4_regfile (.clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata,
                               .dreq, .step, .chan_en, .chan_mode);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bwr(logic [3:0] a, logic [7:0] d);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic brd(logic [3:0] a, output logic [7:0] d);
    cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic pulse(logic [3:0] s);
    step = s;
    @(negedge clk);
    step = '0;
  endtask

  task automatic wr16(logic [3:0] a, logic [15:0] v);
    bwr(4'd12, 8'h00); bwr(a, v[7:0]); bwr(a, v[15:8]);
  endtask

  task automatic rd16(logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    bwr(4'd12, 8'h00); brd(a, lo); brd(a, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R5 reset enables", chan_en, 4'h0);
    chk("R6 reset mode", chan_mode, 24'h0);
    brd(4'd8, s);
    chk("R11 reset status", s, 8'h00);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr16(4'd2, 16'h1234); wr16(4'd3, 16'h0002);
    wr16(4'd6, 16'hBEEF);
    rd16(4'd2, v); chk("R1 ch1 address", v, 16'h1234);
    rd16(4'd3, v); chk("R1 ch1 count", v, 16'h0002);
    rd16(4'd6, v); chk("R1 ch3 address", v, 16'hBEEF);
    bwr(4'd12, 8'h00); bwr(4'd0, 8'hAA);
    bwr(4'd12, 8'h00); bwr(4'd0, 8'h11); bwr(4'd0, 8'h22);
    rd16(4'd0, v); chk("R2 pointer clear", v, 16'h2211);
  endtask

  task automatic t_masks;
    bwr(4'd10, 8'h01); chk("R3 single unmask", chan_en, 4'b0010);
    bwr(4'd10, 8'h05); chk("R3 single mask", chan_en, 4'b0000);
    bwr(4'd15, 8'h05); chk("R4 multi mask", chan_en, 4'b1010);
    bwr(4'd14, 8'hFF); chk("R4 mask reset", chan_en, 4'b1111);
    bwr(4'd8, 8'h04);  chk("R7 disable", chan_en, 4'b0000);
    bwr(4'd8, 8'h00);  chk("R7 re-enable", chan_en, 4'b1111);
  endtask

  task automatic t_mode;
    bwr(4'd11, 8'hDA);
    chk("R6 ch2 mode", chan_mode, {6'h00, 6'h36, 6'h00, 6'h00});
    bwr(4'd11, 8'h02);
  endtask

  task automatic t_step;
    logic [15:0] v; logic [7:0] s;
    bwr(4'd11, 8'h49);
    wr16(4'd2, 16'h1234); wr16(4'd3, 16'h0002);
    bwr(4'd15, 8'h0D);
    pulse(4'b0010);
    rd16(4'd2, v); chk("R8 address inc", v, 16'h1235);
    rd16(4'd3, v); chk("R8 count dec", v, 16'h0001);
    pulse(4'b0010); pulse(4'b0010);
    rd16(4'd2, v); chk("R8 address after 3", v, 16'h1237);
    rd16(4'd3, v); chk("R9 count wrap", v, 16'hFFFF);
    chk("R9 self mask", chan_en, 4'b0000);
    pulse(4'b0010);
    rd16(4'd2, v); chk("R8 masked step ignored", v, 16'h1237);
    brd(4'd8, s); chk("R11 tc flag", s, 8'h02);
    brd(4'd8, s); chk("R11 tc cleared on read", s, 8'h00);
  endtask

  task automatic t_auto;
    logic [15:0] v; logic [7:0] s;
    bwr(4'd11, 8'h7A);
    wr16(4'd4, 16'h0100); wr16(4'd5, 16'h0001);
    bwr(4'd10, 8'h02);
    pulse(4'b0100);
    rd16(4'd4, v); chk("R8 address dec", v, 16'h00FF);
    pulse(4'b0100);
    rd16(4'd4, v); chk("R10 address reload", v, 16'h0100);
    rd16(4'd5, v); chk("R10 count reload", v, 16'h0001);
    chk("R10 stays enabled", chan_en, 4'b0100);
    brd(4'd8, s); chk("R11 tc auto", s, 8'h04);
  endtask

  task automatic t_collide;
    logic [15:0] v; logic [7:0] s;
    bwr(4'd11, 8'h44);
    wr16(4'd0, 16'h0050); wr16(4'd1, 16'h0000);
    bwr(4'd10, 8'h00);
    cs = 1; rd = 1; addr = 4'd8; step = 4'b0001;
    #1 s = rdata;
    @(negedge clk);
    cs = 0; rd = 0; step = '0;
    chk("R11 read with tc step", s, 8'h00);
    brd(4'd8, s); chk("R11 tc survives read", s, 8'h01);
    rd16(4'd0, v); chk("R8 ch0 address", v, 16'h0051);
    bwr(4'd11, 8'h47);
    wr16(4'd6, 16'h0010); wr16(4'd7, 16'h0100);
    bwr(4'd10, 8'h03);
    bwr(4'd12, 8'h00);
    step = 4'b1000;
    bwr(4'd7, 8'h05);
    step = '0;
    rd16(4'd7, v); chk("R12 step dropped count", v, 16'h0105);
    rd16(4'd6, v); chk("R12 step dropped address", v, 16'h0010);
  endtask

  task automatic t_request;
    logic [7:0] s, b;
    dreq = 4'b1000;
    bwr(4'd9, 8'h05);
    brd(4'd8, s); chk("R11 request bits", s, 8'hA0);
    bwr(4'd9, 8'h01);
    brd(4'd8, s); chk("R11 request clear", s, 8'h80);
    bwr(4'd9, 8'h06);
    bwr(4'd12, 8'h00); bwr(4'd0, 8'hAA);
    bwr(4'd13, 8'h00);
    chk("R5 master reset masks", chan_en, 4'h0);
    brd(4'd8, s); chk("R5 master reset status", s, 8'h80);
    brd(4'd0, b); chk("R5 master reset pointer", b, 8'hAA);
    dreq = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_masks;
    t_mode;
    t_step;
    t_auto;
    t_collide;
    t_request;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule